// File: doc/BRIEF.md
# Manchester Transmit Encoder

This block turns serial NRZ data from a network controller into a single-bit Manchester line signal for a 10 Mbit/s link. It runs from a 20 MHz reference clock. It divides that clock by two to form the 10 MHz transmit clock that it hands back to the controller. Each bit cell therefore lasts two reference periods, one for each half-cell. While transmit enable is high, one data bit is taken on each rising edge of the transmit clock and encoded. A `drive_o` flag tells a pad wrapper when the line is being actively driven.

When transmit enable drops, the frame closes with a positive transition followed by a short high tail. The line then settles into one of two idle behaviours, selected by an input. In held-high mode the line stays high for at most 200 ns after the last transition and then rests at a high level. In zero-differential mode the tail is a single half-cell and the line then rests low with the driver released.

A loopback input diverts the encoded stream to a separate tap for a local receiver and keeps the line driver released. The analog driver, slew control and termination sit outside this block.

Top module: `man_tx_enc`

## Requirements
- R1: `txc_o` is low in reset and toggles on every reference clock edge after reset. Its rising edges mark bit-cell starts.
- R2: A frame starts on the first rising edge of `txc_o` at which `txen_i` is high. `txd_i` is sampled on that same edge, and `drive_o` rises with the first half-cell.
- R3: A one is encoded low in the first half-cell and high in the second; a zero is the reverse. Each half-cell is one reference period, and the first half coincides with `txc_o` high.
- R4: The frame ends on the first rising edge of `txc_o` at which `txen_i` is low, and the line then goes or stays high. The final transition is therefore positive: mid-cell when the last bit is one, at the cell end when it is zero.
- R5: With `idle_sel_i` low (held-high mode), the tail keeps `line_o` high and `drive_o` high for HOLD_HC-1 reference periods. This keeps the time from the last transition to idle at or below HOLD_HC periods (200 ns by default).
- R6: With `idle_sel_i` high (zero-differential mode), the tail lasts exactly one reference period.
- R7: When no frame or tail is in progress, `drive_o` is 0 and `line_o` equals the idle level: 1 when `idle_sel_i` is low, 0 when it is high.
- R8: If `txen_i` is high at a `txc_o` rising edge during a tail, a new frame starts at once. `drive_o` stays high throughout.
- R9: With `lbk_i` high, `drive_o` is 0, `line_o` holds the idle level and `lb_o` carries the encoded stream. With `lbk_i` low, `lb_o` is 0.
- R10: In reset, `drive_o` is 0 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txen_i | input | 1 | Transmit enable from the controller |
| txd_i | input | 1 | NRZ transmit data, sampled on `txc_o` rising edge |
| idle_sel_i | input | 1 | Idle mode: 0 held-high, 1 zero-differential |
| lbk_i | input | 1 | Loopback enable |
| txc_o | output | 1 | 10 MHz transmit clock to the controller |
| line_o | output | 1 | Manchester line level |
| drive_o | output | 1 | Line driver enable for the pad wrapper |
| lb_o | output | 1 | Loopback tap of the encoded stream |

## Verification
The bench decodes every bit cell back to data. It thereby catches swapped polarity or a half-cell shifted against the transmit clock, either of which would turn every decoded bit into its complement or break the mid-cell transition. Frames are ended after a one and after a zero in both idle modes, and the exact tail length is checked. A wrong tail would either drop the driver before the positive closing edge or hold the line high longer than the 200 ns limit. Re-asserting enable during a tail exposes a design that finishes the tail first and swallows the next frame's first bit. Loopback frames check that the tap carries the stream while the line stays parked and undriven.

// File: rtl/man_tx_pkg.sv
package man_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_TAIL = 2'd2
  } tx_st_e;
endpackage

// File: rtl/man_tx_clkdiv.sv
module man_tx_clkdiv (
  input  logic clk_i,
  input  logic rst_ni,
  output logic txc_o,
  output logic bit_start_o
);
  logic txc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) txc_q <= 1'b0;
    else         txc_q <= ~txc_q;
  end

  assign txc_o       = txc_q;
  // next edge raises txc: a bit cell begins there
  assign bit_start_o = ~txc_q;

  // R1
  txc_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> txc_q == !$past(txc_q));
endmodule

// File: rtl/man_tx_core.sv
module man_tx_core
  import man_tx_pkg::*;
#(
  parameter  int HOLD_HC = 4,
  localparam int CW      = $clog2(HOLD_HC) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_start_i,
  input  logic txen_i,
  input  logic txd_i,
  input  logic idle_sel_i,
  output logic enc_o,
  output logic active_o
);
  tx_st_e        st_q;
  logic          enc_q;
  logic          bit_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tail_ld;

  // tail periods minus one: HOLD_HC-1 periods held high, or a single one
  assign tail_ld = idle_sel_i ? '0 : CW'(HOLD_HC - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      enc_q <= 1'b0;
      bit_q <= 1'b0;
      cnt_q <= '0;
    end else if (bit_start_i && txen_i) begin
      st_q  <= ST_SEND;
      bit_q <= txd_i;
      enc_q <= ~txd_i;
    end else begin
      case (st_q)
        ST_SEND: begin
          if (bit_start_i) begin
            st_q  <= ST_TAIL;
            enc_q <= 1'b1;
            cnt_q <= tail_ld;
          end else begin
            enc_q <= bit_q;
          end
        end
        ST_TAIL: begin
          if (cnt_q == '0) begin
            st_q  <= ST_IDLE;
            enc_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign enc_o    = enc_q;
  assign active_o = (st_q != ST_IDLE);

  // checker: consecutive tail periods seen so far
  logic [CW:0] tail_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tail_run_q <= '0;
    else if (st_q == ST_TAIL) tail_run_q <= tail_run_q + 1'b1;
    else                      tail_run_q <= '0;
  end

  // R2
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && bit_start_i && txen_i) |=> (st_q == ST_SEND && enc_q == !$past(txd_i)));

  // R3
  mid_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && !bit_start_i) |=> enc_q != $past(enc_q));

  // R4
  tail_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && bit_start_i && !txen_i) |=> (st_q == ST_TAIL && enc_q));

  // R5
  tail_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_run_q <= (CW+1)'(HOLD_HC - 1));

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL && bit_start_i && txen_i) |=> st_q == ST_SEND);
endmodule

// File: rtl/man_tx_outmux.sv
module man_tx_outmux (
  input  logic enc_i,
  input  logic active_i,
  input  logic idle_sel_i,
  input  logic lbk_i,
  output logic line_o,
  output logic drive_o,
  output logic lb_o
);
  logic idle_lvl;

  assign idle_lvl = ~idle_sel_i;
  assign line_o   = (active_i && !lbk_i) ? enc_i : idle_lvl;
  assign drive_o  = active_i && !lbk_i;
  assign lb_o     = lbk_i && active_i && enc_i;
endmodule

// File: rtl/man_tx_enc.sv
module man_tx_enc #(
  parameter int HOLD_HC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txen_i,
  input  logic txd_i,
  input  logic idle_sel_i,
  input  logic lbk_i,
  output logic txc_o,
  output logic line_o,
  output logic drive_o,
  output logic lb_o
);
  logic bit_start;
  logic enc;
  logic active;

  man_tx_clkdiv u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .txc_o      (txc_o),
    .bit_start_o(bit_start)
  );

  man_tx_core #(.HOLD_HC(HOLD_HC)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_start_i(bit_start),
    .txen_i     (txen_i),
    .txd_i      (txd_i),
    .idle_sel_i (idle_sel_i),
    .enc_o      (enc),
    .active_o   (active)
  );

  man_tx_outmux u_out (
    .enc_i     (enc),
    .active_i  (active),
    .idle_sel_i(idle_sel_i),
    .lbk_i     (lbk_i),
    .line_o    (line_o),
    .drive_o   (drive_o),
    .lb_o      (lb_o)
  );

  // R4
  drive_fall_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(drive_o) && !lbk_i && $past(!lbk_i)) |-> $past(line_o));
endmodule

// File: tb/man_tx_enc_test.sv
module man_tx_enc_test;
  localparam int HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txen = 1'b0, txd = 1'b0, sel = 1'b0, lbk = 1'b0;
  logic txc, line, drv, lb;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  man_tx_enc #(.HOLD_HC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .txen_i(txen), .txd_i(txd),
    .idle_sel_i(sel), .lbk_i(lbk),
    .txc_o(txc), .line_o(line), .drive_o(drv), .lb_o(lb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (txc !== 1'b0) @(negedge clk);
  endtask

  // caller has just dropped txen at a negedge with txc low
  task automatic tail_chk(input logic mode, input logic lbm);
    int tl = mode ? 1 : HOLD - 1;
    for (int k = 0; k < tl; k++) begin
      @(negedge clk);
      chk(k == 0 ? "R4" : "R5", lbm ? lb : line, 1'b1);
      chk(mode ? "R6" : "R5", drv, ~lbm);
    end
    @(negedge clk);
    chk(mode ? "R6" : "R5", drv, 1'b0);
    chk("R7", line, ~mode);
    chk("R9", lb, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", drv, 1'b0);
    chk("R1", txc, 1'b0);
    chk("R7", line, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", txc, 1'b1);
    @(negedge clk);
    chk("R1", txc, 1'b0);
    sel = 1'b1;
    @(negedge clk);
    chk("R7", line, 1'b0);
    chk("R7", drv, 1'b0);
    sel = 1'b0;
  endtask

  task automatic t_frame(input logic [15:0] bits, input int n, input logic mode, input logic lbm);
    logic a, b;
    logic [15:0] dec  = '0;
    logic [15:0] mask = (16'h1 << n) - 16'h1;
    sel = mode; lbk = lbm;
    align();
    for (int i = 0; i < n; i++) begin
      txen = 1'b1; txd = bits[i];
      @(negedge clk);
      a = lbm ? lb : line;
      chk("R1", txc, 1'b1);
      chk(i == 0 ? "R2" : "R3", a, ~bits[i]);
      chk("R2", drv, ~lbm);
      if (lbm) chk("R9", line, ~mode);
      else     chk("R9", lb, 1'b0);
      @(negedge clk);
      b = lbm ? lb : line;
      chk("R3", b, bits[i]);
      dec[i] = (a != b) ? b : 1'bx;
    end
    chk("R3", (dec & mask) === (bits & mask), 1'b1);
    txen = 1'b0; txd = 1'b0;
    tail_chk(mode, lbm);
    lbk = 1'b0;
  endtask

  task automatic t_restart();
    sel = 1'b0; lbk = 1'b0;
    align();
    txen = 1'b1; txd = 1'b1;
    repeat (2) @(negedge clk);
    txen = 1'b0;
    @(negedge clk);
    chk("R8", line, 1'b1);
    chk("R8", drv, 1'b1);
    @(negedge clk);
    chk("R8", line, 1'b1);
    txen = 1'b1; txd = 1'b0;
    @(negedge clk);
    chk("R8", line, 1'b1);
    chk("R8", drv, 1'b1);
    @(negedge clk);
    chk("R8", line, 1'b0);
    chk("R8", drv, 1'b1);
    txen = 1'b0;
    tail_chk(1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_frame(16'h00B5, 8, 1'b0, 1'b0);  // ends on one, held-high
    t_frame(16'h0036, 7, 1'b1, 1'b0);  // ends on zero, zero-diff
    t_frame(16'h0036, 7, 1'b0, 1'b0);  // ends on zero, held-high
    t_frame(16'hC3A9, 16, 1'b1, 1'b0); // ends on one, zero-diff
    t_frame(16'h005A, 8, 1'b0, 1'b1);  // loopback
    t_frame(16'h0003, 3, 1'b1, 1'b1);  // loopback, zero-diff
    t_restart();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule